// File: doc/BRIEF.md
# Single-Clock FIFO with Selectable Look-Ahead Output

This block is a first-in first-out buffer in which writer and reader share one rising-edge clock. A producer presents a word with a write request, and a consumer takes words in arrival order with a read request. The block reports when it is full, when it is empty, and how many words it holds. Storage is an inferred array whose depth and width are parameters.

Compile-time parameters set how the block behaves. The read side can run in registered mode, where a read loads the oldest word into the output register on the clock edge. It can instead run in look-ahead mode, where the oldest word is already on the output while the buffer holds data, and a read moves on to the next word. The guard that drops writes while full and the guard that drops reads while empty are switched separately. A further option lets a read and a write on the same edge go through while the buffer is full, so that it stays full. The option has an effect only while the write guard is on.

An asynchronous clear and a synchronous clear both empty the buffer. The asynchronous clear wins over the synchronous one, and the synchronous clear wins over any read or write on the same edge. After either clear, the output reads as all zeros.

Top module: `sync_fifo_sa`

## Requirements
- R1: `full` is 1 exactly when the stored word count equals DEPTH, and `empty` is 1 exactly when the count is zero.
- R2: `used_cnt` is ceil(log2(DEPTH)) bits wide and carries the word count modulo 2^width, so with a power-of-two depth it reads 0 while `full` is 1.
- R3: With the write guard on, a write request while full, with no read on the same edge, is dropped: the count and the stored words are unchanged.
- R4: With the read guard on, a read request while empty is dropped: the count stays zero and, in registered mode, `rd_data` keeps its value.
- R5: In registered mode, an accepted read loads the oldest stored word into `rd_data` on that edge, and `rd_data` holds its value on any edge without a read request.
- R6: In look-ahead mode, `rd_data` shows the oldest stored word whenever the buffer is not empty and reads zero when it is empty, and an accepted read advances it to the next word.
- R7: A read and a write on the same edge that are both accepted each take effect: the new word is appended, the oldest word is consumed, and the count is unchanged.
- R8: With the write guard and the full-cycle option both on, a read and a write on the same edge while full are both accepted and `full` stays 1. With the option off, only the read takes effect and the count falls by one.
- R9: Raising `arst` empties the buffer and sets `rd_data` to zero at once, without waiting for a clock edge, and it overrides `sclr`.
- R10: `sclr` high on a rising edge empties the buffer and sets `rd_data` to zero on that edge, and any read or write request on that edge is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all state |
| arst | input | 1 | Asynchronous clear, active high |
| sclr | input | 1 | Synchronous clear, active high |
| wr_data | input | DATA_W | Word to store |
| wr_req | input | 1 | Write request |
| rd_req | input | 1 | Read request |
| rd_data | output | DATA_W | Oldest word (look-ahead) or last word read (registered) |
| full | output | 1 | Count equals DEPTH |
| empty | output | 1 | Count is zero |
| used_cnt | output | CNT_W | Word count, modulo 2^CNT_W |

## Verification
The bench builds two instances side by side and gives both the same stimulus. The first uses registered mode, depth 8, both guards on and the full-cycle option off. It covers the count wrapping to zero at full, a write that is dropped at full, and a read plus write at full in which only the read takes effect. The second uses look-ahead mode, depth 5, both guards on and the full-cycle option on. Its depth is not a power of two, so the pointers wrap at an odd boundary, and a read plus write at full keeps it full.

// File: rtl/fifo_sa_pkg.sv
package fifo_sa_pkg;

  // Advance a storage index, wrapping at the configured depth.
  function automatic int unsigned ptr_step(input int unsigned p, input int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // Word count after one edge, given which accesses were accepted.
  function automatic int unsigned lvl_next(input int unsigned lvl, input logic w, input logic r);
    return lvl + 32'(w) - 32'(r);
  endfunction

endpackage

// File: rtl/fifo_sa_ctrl.sv
module fifo_sa_ctrl #(
  parameter int DEPTH     = 8,
  parameter int AW        = 3,
  parameter bit GUARD_OVF = 1'b1,
  parameter bit GUARD_UNF = 1'b1,
  parameter bit RW_FULL   = 1'b0
) (
  input  logic          clk,
  input  logic          arst,
  input  logic          sclr,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          wr_go,
  output logic          rd_go,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [AW:0]   level,
  output logic          full,
  output logic          empty
);
  import fifo_sa_pkg::*;
  localparam int LW = AW + 1;

  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);

  // Acceptance of each request, per the guard options.
  assign rd_go = rd_req && (!GUARD_UNF || !empty);
  assign wr_go = wr_req && (!GUARD_OVF || !full || (RW_FULL && rd_req));

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (sclr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (wr_go) wr_ptr <= AW'(ptr_step(32'(wr_ptr), DEPTH));
      if (rd_go) rd_ptr <= AW'(ptr_step(32'(rd_ptr), DEPTH));
      level <= LW'(lvl_next(32'(level), wr_go, rd_go));
    end
  end
endmodule

// File: rtl/fifo_sa_mem.sv
module fifo_sa_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/fifo_sa_qreg.sv
module fifo_sa_qreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              arst,
  input  logic              sclr,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or posedge arst) begin
    if (arst)      q <= '0;
    else if (sclr) q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/sync_fifo_sa.sv
module sync_fifo_sa #(
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 8,
  parameter bit SHOW_AHEAD = 1'b0,
  parameter bit GUARD_OVF  = 1'b1,
  parameter bit GUARD_UNF  = 1'b1,
  parameter bit RW_FULL    = 1'b0,
  localparam int CNT_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              arst,
  input  logic              sclr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_req,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  used_cnt
);
  logic              wr_go, rd_go;
  logic [CNT_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W:0]    level;
  logic [DATA_W-1:0] head_word;

  fifo_sa_ctrl #(
    .DEPTH(DEPTH), .AW(CNT_W), .GUARD_OVF(GUARD_OVF),
    .GUARD_UNF(GUARD_UNF), .RW_FULL(RW_FULL)
  ) u_ctrl (
    .clk(clk), .arst(arst), .sclr(sclr), .wr_req(wr_req), .rd_req(rd_req),
    .wr_go(wr_go), .rd_go(rd_go), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .level(level), .full(full), .empty(empty)
  );

  fifo_sa_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(CNT_W)) u_mem (
    .clk(clk), .we(wr_go && !sclr), .waddr(wr_ptr), .wdata(wr_data),
    .raddr(rd_ptr), .rdata(head_word)
  );

  assign used_cnt = level[CNT_W-1:0];

  generate
    if (SHOW_AHEAD) begin : g_look
      assign rd_data = empty ? '0 : head_word;
    end else begin : g_reg
      fifo_sa_qreg #(.DATA_W(DATA_W)) u_q (
        .clk(clk), .arst(arst), .sclr(sclr), .load(rd_go),
        .d(head_word), .q(rd_data)
      );
    end
  endgenerate
endmodule

// File: rtl/fifo_sa_chk.sv
module fifo_sa_chk #(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 3,
  parameter bit SHOW_AHEAD = 1'b0,
  parameter bit GUARD_OVF  = 1'b1,
  parameter bit GUARD_UNF  = 1'b1,
  parameter bit RW_FULL    = 1'b0
) (
  input logic              clk,
  input logic              arst,
  input logic              sclr,
  input logic              wr_req,
  input logic              rd_req,
  input logic [DATA_W-1:0] rd_data,
  input logic              full,
  input logic              empty,
  input logic [CNT_W-1:0]  used_cnt,
  input logic              wr_go,
  input logic              rd_go
);
  // R1: never full and empty together
  p_not_full_and_empty_r1: assert property (@(posedge clk) disable iff (arst)
    !(full && empty));

  // R3: a lone write at full leaves the buffer full with the same count
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (arst)
    (GUARD_OVF && full && wr_req && !rd_req && !sclr) |=> (full && $stable(used_cnt)));

  // R4: a lone read while empty leaves it empty
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (arst)
    (GUARD_UNF && empty && rd_req && !wr_req && !sclr) |=> empty);

  // R5: registered output holds without a read request
  p_hold_q_r5: assert property (@(posedge clk) disable iff (arst)
    (!SHOW_AHEAD && !rd_req && !sclr) |=> $stable(rd_data));

  // R6: look-ahead output is zero while empty
  p_look_zero_r6: assert property (@(posedge clk) disable iff (arst)
    (SHOW_AHEAD && empty) |-> (rd_data == '0));

  // R7: accepted read plus write keeps the count
  p_rw_count_r7: assert property (@(posedge clk) disable iff (arst)
    (wr_go && rd_go && !sclr) |=> $stable(used_cnt));

  // R8: combined cycle at full stays full when the option is on
  p_rw_full_r8: assert property (@(posedge clk) disable iff (arst)
    (GUARD_OVF && RW_FULL && full && wr_req && rd_req && !sclr) |=> full);

  // R10: synchronous clear empties and zeroes the output
  p_sclr_r10: assert property (@(posedge clk) disable iff (arst)
    sclr |=> (empty && rd_data == '0));
endmodule

bind sync_fifo_sa fifo_sa_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .SHOW_AHEAD(SHOW_AHEAD),
  .GUARD_OVF(GUARD_OVF), .GUARD_UNF(GUARD_UNF), .RW_FULL(RW_FULL)
) u_chk (
  .clk(clk), .arst(arst), .sclr(sclr), .wr_req(wr_req), .rd_req(rd_req),
  .rd_data(rd_data), .full(full), .empty(empty), .used_cnt(used_cnt),
  .wr_go(wr_go), .rd_go(rd_go)
);

// File: tb/tb_sync_fifo_sa.sv
`timescale 1ns/1ps
module tb_sync_fifo_sa;
  logic       clk = 1'b0;
  logic       arst = 1'b1;
  logic       sclr = 1'b0;
  logic       wr_req = 1'b0;
  logic       rd_req = 1'b0;
  logic [7:0] wr_data = 8'h00;

  logic [7:0] rd_a, rd_b;
  logic       full_a, empty_a, full_b, empty_b;
  logic [2:0] used_a, used_b;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  // A: registered output, depth 8, guards on, full-cycle option off
  sync_fifo_sa #(.DATA_W(8), .DEPTH(8), .SHOW_AHEAD(1'b0), .GUARD_OVF(1'b1),
                 .GUARD_UNF(1'b1), .RW_FULL(1'b0)) dut (
    .clk(clk), .arst(arst), .sclr(sclr), .wr_data(wr_data), .wr_req(wr_req),
    .rd_req(rd_req), .rd_data(rd_a), .full(full_a), .empty(empty_a), .used_cnt(used_a));

  // B: look-ahead output, depth 5, guards on, full-cycle option on
  sync_fifo_sa #(.DATA_W(8), .DEPTH(5), .SHOW_AHEAD(1'b1), .GUARD_OVF(1'b1),
                 .GUARD_UNF(1'b1), .RW_FULL(1'b1)) dut_b (
    .clk(clk), .arst(arst), .sclr(sclr), .wr_data(wr_data), .wr_req(wr_req),
    .rd_req(rd_req), .rd_data(rd_b), .full(full_b), .empty(empty_b), .used_cnt(used_b));

  // Reference model state
  logic [7:0] qa[$];
  logic [7:0] qb[$];
  logic [7:0] outa = 8'h00;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R5 registered q (A)", 32'(rd_a), 32'(outa));
    chk("R1 full (A)", 32'(full_a), 32'(qa.size() == 8));
    chk("R1 empty (A)", 32'(empty_a), 32'(qa.size() == 0));
    chk("R2 used count mod 8 (A)", 32'(used_a), 32'(qa.size() % 8));
    chk("R6 look-ahead q (B)", 32'(rd_b), (qb.size() > 0) ? 32'(qb[0]) : 32'h0);
    chk("R1 full (B)", 32'(full_b), 32'(qb.size() == 5));
    chk("R1 empty (B)", 32'(empty_b), 32'(qb.size() == 0));
    chk("R2 used count (B)", 32'(used_b), 32'(qb.size()));
  endtask

  task automatic model_clear();
    qa.delete();
    qb.delete();
    outa = 8'h00;
  endtask

  // One clock: drive at the current (falling-edge) time, update model at
  // the rising edge, compare at the next falling edge.
  task automatic step(input logic w, input logic r, input logic s);
    logic wa, ra, wb, rb;
    wr_req = w; rd_req = r; sclr = s;
    @(posedge clk);
    if (s) begin
      model_clear(); // R10
    end else begin
      ra = r && (qa.size() > 0);
      wa = w && (qa.size() < 8);          // R3, R8 (option off)
      rb = r && (qb.size() > 0);
      wb = w && ((qb.size() < 5) || r);   // R8 (option on)
      if (ra) outa = qa.pop_front();
      if (wa) qa.push_back(wr_data);
      if (rb) void'(qb.pop_front());
      if (wb) qb.push_back(wr_data);
    end
    @(negedge clk);
    wr_data = wr_data + 8'h1;
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    arst = 1'b0;
    model_clear();
    compare_all(); // reset state, R1 R2

    // Fill both; B blocks extra writes beyond 5 (R3)
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b0);
    chk("R2 used wraps to 0 at full (A)", 32'(used_a), 32'h0);
    chk("R3 B stays full after dropped writes", 32'(used_b), 32'd5);

    // Write at full without read: dropped (R3)
    step(1'b1, 1'b0, 1'b0);
    chk("R3 A still full", 32'(full_a), 32'h1);

    // Read plus write at full (R8)
    step(1'b1, 1'b1, 1'b0);
    chk("R8 option off: A count falls to 7", 32'(used_a), 32'd7);
    chk("R8 option on: B stays full", 32'(full_b), 32'h1);

    // Drain past empty (R4, R5, R6)
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b0);
    chk("R4 A empty after over-read", 32'(empty_a), 32'h1);
    chk("R4 B empty after over-read", 32'(empty_b), 32'h1);

    // Read plus write while empty: only the write lands (R4, R7)
    step(1'b1, 1'b1, 1'b0);
    chk("R4 A holds one word", 32'(used_a), 32'd1);
    // Read plus write with one word: count unchanged (R7)
    step(1'b1, 1'b1, 1'b0);
    chk("R7 A count unchanged", 32'(used_a), 32'd1);
    chk("R7 B count unchanged", 32'(used_b), 32'd1);

    // Mixed traffic pattern
    for (int i = 0; i < 60; i++) begin
      case (i % 5)
        0, 1:    step(1'b1, 1'b0, 1'b0);
        2:       step(1'b1, 1'b1, 1'b0);
        3:       step(1'b0, 1'b1, 1'b0);
        default: step(1'b0, 1'b0, 1'b0);
      endcase
    end
    for (int i = 0; i < 12; i++) step(1'b0, 1'b1, (i % 4) == 3 ? 1'b0 : 1'b0);

    // Synchronous clear beats read and write on the same edge (R10)
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b1);
    chk("R10 A empty after sclr", 32'(empty_a), 32'h1);
    chk("R10 A q zero after sclr", 32'(rd_a), 32'h0);
    chk("R10 B empty after sclr", 32'(empty_b), 32'h1);

    // Asynchronous clear with sclr low, acts before any edge (R9)
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    wr_req = 1'b0; rd_req = 1'b0; sclr = 1'b0;
    #3 arst = 1'b1;
    #2;
    model_clear();
    chk("R9 A empty without edge", 32'(empty_a), 32'h1);
    chk("R9 A q zero without edge", 32'(rd_a), 32'h0);
    chk("R9 B empty without edge", 32'(empty_b), 32'h1);
    #2 arst = 1'b0;
    @(negedge clk);
    compare_all();
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule